// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings a group of switchable power domains from fully off to fully on, one domain at a time. Each domain has a seven-bit control word and a set of SRAM power-down lines. The sequencer steps through them in a fixed order, and each change to a control bit takes its own clock cycle. It waits on status acknowledges from the two-stage power switch and from the domain's SRAM banks before it moves on.

For every domain, the sequencer first writes an enable key to a configuration output. It then turns on the first power stage and after that the second. It waits until both switch acknowledges are high. It then releases, in this order, the clock gate, the isolation clamp, the reset and the SRAM power-down lines. After that it waits for every SRAM acknowledge to drop.

Domains that have SRAM isolation get one more step. The sequencer lifts SRAM isolation, waits a timed interval of at least one microsecond, and then releases the SRAM clock isolation.

A single start pulse launches the whole group in index order. A busy flag and a done flag report progress. Each acknowledge wait has an optional timeout that halts the sequence and raises an error flag.

Top module: `pd_seq_group`

## Requirements
- R1: After reset, every domain's control word is 0x32: reset_n (bit0) is 0, isolation (bit1) is 1, power-on (bit2) is 0, second power-on (bit3) is 0, clock disable (bit4) is 1, SRAM clock isolation (bit5) is 1 and SRAM isolation_n (bit6) is 0. After reset, all `sram_pdn` lines are 1, and `cfg_key`, `busy`, `done` and `err` are all 0.
- R2: A start pulse while idle raises `busy` on the next clock edge. Before the first domain's power-on rises, `cfg_key` reads {PROJ, 15'b0, 1'b1}.
- R3: Within a domain, bit2 rises exactly one cycle before bit3 rises.
- R4: Bit4 of a domain does not clear while either of that domain's two power acknowledges (`pwr_ack`, `pwr_ack2`) is low.
- R5: After both power acknowledges are seen, the releases come on four successive cycles, in this order: bit4 clears, bit1 clears, bit0 sets, then the domain's `sram_pdn` lines clear.
- R6: After the domain's `sram_pdn` lines clear, the sequence does not advance until all of that domain's `sram_ack` bits are 0.
- R7: For a domain whose bit is set in ISO_CAP, bit6 sets first. Bit5 clears at least DLY cycles later, where DLY is ceil(CLK_MHZ*ISO_NS/1000). In every other domain, bits 6 and 5 keep their reset values. The final control word is 0x4D for a domain with SRAM isolation and 0x2D for a domain without it.
- R8: Domains power on strictly in index order. Domain d+1's bit2 rises only after domain d has finished its last step.
- R9: `done` rises, and `busy` falls, on the same cycle, after the last domain finishes. `done` then holds until the next accepted start.
- R10: A start pulse while `busy` is high is ignored. No domain repeats its power-on.
- R11: If an acknowledge wait lasts TMO cycles (when TMO is not 0), `err` is set, `busy` drops and all control outputs freeze. A later start clears `err` and runs the sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the group sequence when idle |
| pwr_ack | input | N_DOM | First-stage power switch acknowledge, one per domain |
| pwr_ack2 | input | N_DOM | Second-stage power switch acknowledge, one per domain |
| sram_ack | input | N_DOM*SRAM_W | SRAM power-down acknowledges; domain d uses bits d*SRAM_W and up |
| ctl | output | N_DOM*7 | Control words; domain d uses bits d*7 and up |
| sram_pdn | output | N_DOM*SRAM_W | SRAM power-down lines, one group per domain |
| cfg_key | output | 32 | Enable key written before each domain switches on |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Whole group powered on |
| err | output | 1 | An acknowledge wait timed out |

## Verification
The hardest states to reach are a sequence parked in the middle, either holding after both power stages are on but before the clock release, or holding after SRAM power-down clears but before SRAM isolation lifts. The bench's acknowledge models follow the control outputs with a short delay. Hold flags can freeze those models, so the sequencer sits in one wait long enough to inspect the outputs and then resumes. Holding an acknowledge past TMO drives the error path, and a second start afterwards confirms that the sequence recovers.

// File: rtl/pd_seq_group.sv
module pd_seq_group #(
  parameter int N_DOM = 3,
  parameter int SRAM_W = 4,
  parameter int CLK_MHZ = 200,
  parameter int ISO_NS = 1000,
  parameter int TMO = 1000,
  parameter int unsigned ISO_CAP = 5,
  parameter logic [15:0] PROJ = 16'h0b16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [N_DOM-1:0]          pwr_ack,
  input  logic [N_DOM-1:0]          pwr_ack2,
  input  logic [N_DOM*SRAM_W-1:0]   sram_ack,
  output logic [N_DOM*7-1:0]        ctl,
  output logic [N_DOM*SRAM_W-1:0]   sram_pdn,
  output logic [31:0]               cfg_key,
  output logic                      busy,
  output logic                      done,
  output logic                      err
);
  localparam int DLY  = (CLK_MHZ * ISO_NS + 999) / 1000;
  localparam int CMAX = (DLY > TMO) ? DLY : TMO;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int IW   = (N_DOM > 1) ? $clog2(N_DOM) : 1;
  localparam logic [31:0] CAPV = 32'(ISO_CAP);
  localparam logic [6:0]  OFF_W = 7'h32;

  typedef enum logic [3:0] {
    S_IDLE, S_KEY, S_PON, S_PON2, S_WACK, S_CLK, S_ISO, S_RST,
    S_SRAM, S_WSRAM, S_SISO, S_WDLY, S_CKISO, S_NEXT
  } st_t;

  st_t st;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [6:0] cw [N_DOM];
  logic [SRAM_W-1:0] pdn [N_DOM];

  wire tmo_hit = (TMO != 0) && (cnt == CW'(TMO - 1));
  wire acks_in = pwr_ack[idx] & pwr_ack2[idx];
  wire sram_clr = (sram_ack[idx*SRAM_W +: SRAM_W] == '0);

  for (genvar d = 0; d < N_DOM; d++) begin : g_out
    assign ctl[d*7 +: 7] = cw[d];
    assign sram_pdn[d*SRAM_W +: SRAM_W] = pdn[d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0;
      cnt <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
      cfg_key <= '0;
      for (int d = 0; d < N_DOM; d++) begin
        cw[d] <= OFF_W;
        pdn[d] <= '1;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1;
          done <= 1'b0;
          err <= 1'b0;
          idx <= '0;
          st <= S_KEY;
        end
        S_KEY: begin
          cfg_key <= {PROJ, 15'd0, 1'b1};
          st <= S_PON;
        end
        S_PON: begin
          cw[idx][2] <= 1'b1;
          st <= S_PON2;
        end
        S_PON2: begin
          cw[idx][3] <= 1'b1;
          cnt <= '0;
          st <= S_WACK;
        end
        S_WACK: begin
          if (acks_in) st <= S_CLK;
          else if (tmo_hit) begin
            err <= 1'b1;
            busy <= 1'b0;
            st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_CLK: begin
          cw[idx][4] <= 1'b0;
          st <= S_ISO;
        end
        S_ISO: begin
          cw[idx][1] <= 1'b0;
          st <= S_RST;
        end
        S_RST: begin
          cw[idx][0] <= 1'b1;
          st <= S_SRAM;
        end
        S_SRAM: begin
          pdn[idx] <= '0;
          cnt <= '0;
          st <= S_WSRAM;
        end
        S_WSRAM: begin
          if (sram_clr) st <= CAPV[idx] ? S_SISO : S_NEXT;
          else if (tmo_hit) begin
            err <= 1'b1;
            busy <= 1'b0;
            st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_SISO: begin
          cw[idx][6] <= 1'b1;
          cnt <= '0;
          st <= S_WDLY;
        end
        S_WDLY: begin
          if (cnt == CW'(DLY - 1)) st <= S_CKISO;
          else cnt <= cnt + 1'b1;
        end
        S_CKISO: begin
          cw[idx][5] <= 1'b0;
          st <= S_NEXT;
        end
        S_NEXT: begin
          if (idx == IW'(N_DOM - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st <= S_KEY;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pd_seq_group_chk.sv
module pd_seq_group_chk #(
  parameter int N_DOM = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_DOM-1:0]   pwr_ack,
  input logic [N_DOM-1:0]   pwr_ack2,
  input logic [N_DOM*7-1:0] ctl,
  input logic               busy,
  input logic               done,
  input logic               err
);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    a_r3_on_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl[d*7+3]) |-> $past(ctl[d*7+2]));
    a_r4_ack_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl[d*7+4]) |-> $past(pwr_ack[d] && pwr_ack2[d], 2));
    a_r5_iso_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl[d*7+1]) |-> !$past(ctl[d*7+4]));
    if (d > 0) begin : g_ord
      a_r8_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl[d*7+2]) |-> ctl[(d-1)*7]);
    end
  end
endmodule

bind pd_seq_group pd_seq_group_chk #(.N_DOM(N_DOM)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2),
  .ctl(ctl), .busy(busy), .done(done), .err(err)
);

// File: tb/pd_seq_group_test.sv
module pd_seq_group_test;
  localparam int N = 3;
  localparam int W = 4;
  localparam int DLY = 200;
  localparam int TMO = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] pa, pa2, p1, p21;
  logic [N*W-1:0] sa;
  logic [N*7-1:0] ctl;
  logic [N*W-1:0] pdn;
  logic [31:0] key;
  logic busy, done, err;
  logic hold_pwr = 1'b0, hold_sram = 1'b0;

  int errors = 0, checks = 0, cyc = 0;
  int t_on[N], t_on2[N], t_clk[N], t_iso[N], t_rst[N], t_pdn[N], t_isob[N], t_ckiso[N], n_on[N];
  logic [31:0] key_at_on;
  logic [N*7-1:0] pctl;
  logic [N*W-1:0] ppdn;

  always #2.5 clk = ~clk;

  pd_seq_group #(.N_DOM(N), .SRAM_W(W), .CLK_MHZ(200), .ISO_NS(1000), .TMO(TMO),
                 .ISO_CAP(5), .PROJ(16'h0b16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_ack(pa), .pwr_ack2(pa2),
    .sram_ack(sa), .ctl(ctl), .sram_pdn(pdn), .cfg_key(key),
    .busy(busy), .done(done), .err(err));

  always @(posedge clk) begin
    for (int d = 0; d < N; d++) begin
      p1[d]  <= ctl[d*7+2] & ~hold_pwr;
      p21[d] <= ctl[d*7+3] & ~hold_pwr;
    end
    pa  <= p1;
    pa2 <= p21;
    sa  <= hold_sram ? '1 : pdn;
  end

  task automatic clear_stamps();
    for (int d = 0; d < N; d++) begin
      t_on[d] = -1; t_on2[d] = -1; t_clk[d] = -1; t_iso[d] = -1;
      t_rst[d] = -1; t_pdn[d] = -1; t_isob[d] = -1; t_ckiso[d] = -1; n_on[d] = 0;
    end
    key_at_on = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int d = 0; d < N; d++) begin
        if (ctl[d*7+2] && !pctl[d*7+2]) begin
          t_on[d] = cyc; n_on[d]++;
          if (d == 0) key_at_on = key;
        end
        if (ctl[d*7+3] && !pctl[d*7+3]) t_on2[d] = cyc;
        if (!ctl[d*7+4] && pctl[d*7+4]) t_clk[d] = cyc;
        if (!ctl[d*7+1] && pctl[d*7+1]) t_iso[d] = cyc;
        if (ctl[d*7+0] && !pctl[d*7+0]) t_rst[d] = cyc;
        if (pdn[d*W +: W] == '0 && ppdn[d*W +: W] != '0) t_pdn[d] = cyc;
        if (ctl[d*7+6] && !pctl[d*7+6]) t_isob[d] = cyc;
        if (!ctl[d*7+5] && pctl[d*7+5]) t_ckiso[d] = cyc;
      end
    end
    pctl = ctl;
    ppdn = pdn;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    hold_pwr = 1'b0; hold_sram = 1'b0; start = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_stamps();
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim && !done && !err; i++) @(negedge clk);
  endtask

  function automatic logic [6:0] fin(input int d);
    return (d == 1) ? 7'h2D : 7'h4D;
  endfunction

  task automatic t_reset();
    do_reset();
    for (int d = 0; d < N; d++) chk(ctl[d*7 +: 7] == 7'h32, "R1", "reset word", ctl[d*7 +: 7], 7'h32);
    chk(pdn == '1 && key == 0, "R1", "pdn/key", {pdn, key}, {12'hfff, 32'h0});
    chk({busy, done, err} == 3'b000, "R1", "flags", {busy, done, err}, 0);
  endtask

  task automatic t_normal();
    do_reset();
    pulse_start();
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    wait_end(5000);
    chk(done && !busy && !err, "R9", "done/busy", {done, busy, err}, 3'b100);
    chk(key_at_on == 32'h0b16_0001, "R2", "key before power-on", key_at_on, 32'h0b16_0001);
    chk(pdn == '0, "R5", "sram pdn cleared", pdn, 0);
    for (int d = 0; d < N; d++) begin
      chk(ctl[d*7 +: 7] == fin(d), "R7", "final word", ctl[d*7 +: 7], fin(d));
      chk(t_on2[d] == t_on[d] + 1, "R3", "on2 one cycle after on", t_on2[d] - t_on[d], 1);
      chk(t_iso[d] == t_clk[d] + 1 && t_rst[d] == t_iso[d] + 1 && t_pdn[d] == t_rst[d] + 1,
          "R5", "release order", {t_clk[d], t_iso[d], t_rst[d], t_pdn[d]}, 0);
      if (d != 1) chk(t_ckiso[d] - t_isob[d] >= DLY, "R7", "sram iso delay", t_ckiso[d] - t_isob[d], DLY);
      if (d > 0) chk(t_on[d] > ((d - 1 == 1) ? t_pdn[d-1] : t_ckiso[d-1]), "R8", "domain order", t_on[d], t_ckiso[d-1]);
    end
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R9", "done held", done, 1);
  endtask

  task automatic t_busy_start();
    do_reset();
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    wait_end(5000);
    for (int d = 0; d < N; d++) chk(n_on[d] == 1, "R10", "power-on count", n_on[d], 1);
    chk(done && ctl[6:0] == 7'h4D, "R10", "domain0 intact", ctl[6:0], 7'h4D);
  endtask

  task automatic t_ack_stall();
    int rel;
    do_reset();
    hold_pwr = 1'b1;
    pulse_start();
    repeat (100) @(negedge clk);
    chk(ctl[6:0] == 7'h3E && busy, "R4", "held before clock release", ctl[6:0], 7'h3E);
    hold_pwr = 1'b0; rel = cyc;
    wait_end(5000);
    chk(t_clk[0] > rel + 2, "R4", "release after ack", t_clk[0], rel + 3);
    chk(done == 1'b1, "R4", "completes after stall", done, 1);
  endtask

  task automatic t_sram_stall();
    do_reset();
    hold_sram = 1'b1;
    pulse_start();
    repeat (100) @(negedge clk);
    chk(ctl[6] == 1'b0 && ctl[7+2] == 1'b0 && busy, "R6", "held on sram ack", {ctl[6], ctl[9]}, 0);
    chk(ctl[6:0] == 7'h2D, "R6", "domain0 word in sram wait", ctl[6:0], 7'h2D);
    hold_sram = 1'b0;
    wait_end(5000);
    chk(done && ctl[6:0] == 7'h4D, "R6", "completes after sram ack", ctl[6:0], 7'h4D);
  endtask

  task automatic t_timeout();
    logic [N*7-1:0] snap;
    do_reset();
    hold_pwr = 1'b1;
    pulse_start();
    wait_end(TMO + 100);
    chk(err && !busy && !done, "R11", "timeout flags", {err, busy, done}, 3'b100);
    chk(ctl[6:0] == 7'h3E, "R11", "halted word", ctl[6:0], 7'h3E);
    snap = ctl;
    repeat (50) @(negedge clk);
    chk(ctl == snap, "R11", "outputs frozen", ctl, snap);
    hold_pwr = 1'b0;
    repeat (5) @(negedge clk);
    pulse_start();
    chk(err == 1'b0 && busy, "R11", "restart clears err", {err, busy}, 1);
    wait_end(5000);
    chk(done == 1'b1, "R11", "restart completes", done, 1);
  endtask

  initial begin
    #750us;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_stamps();
    t_reset();
    t_normal();
    t_busy_start();
    t_ack_stall();
    t_sram_stall();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule